// File: doc/BRIEF.md
# Int8 Sub-Block Codeword Scoring Array

This block scores every possible 8-bit decoded label of one length-8 polar sub-block with a single fully connected layer. It takes an 8-bit frozen mask and eight signed 8-bit LLRs. For each of the 256 labels it forms one signed score from int8 weights and an int8 bias. A downstream selector later picks the label with the largest score.

The weight and bias values are not stored in RAM and are not loaded from a file. A fixed arithmetic rule inside the design computes each one from the channel index and the column index. A mask bit contributes through a select element that passes either the weight or zero. Each LLR contributes through a signed multiplier. The block accepts an input vector only while it is idle. It then streams the scores out in ascending channel order, P channels per cycle. Each score is tagged with its channel index, and the final group carries a last flag.

Top module: `sbs_score_engine`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_last` are 0.
- R2: When `in_valid` is high and `busy` is low at a rising edge, the block captures `in_mask` and `in_llr`, and `busy` is 1 from the next cycle.
- R3: `in_valid` has no effect while `busy` is high. The pass in progress keeps producing the scores of the captured vector, and no extra pass follows.
- R4: Each set mask bit j (bit j of `in_mask`, j = 0..7) adds the weight W(c, j) to the score of channel c. A clear mask bit adds 0.
- R5: Each LLR j (signed byte `in_llr[8j+7:8j]`) adds the signed product W(c, 8+j) × LLR_j to the score of channel c.
- R6: W(c, k) is the low byte of 37c + 101k + 13(c XOR k) + 7, read as two's complement. The bias of channel c is the low byte of 53c + 29, read as two's complement. The bias is added to every score.
- R7: The first output group appears one cycle after acceptance. Groups then follow on consecutive cycles, 256/P groups in all. Lane k of group g carries channel g·P + k in `out_chan[8k+7:8k]` and its score in `out_score[ACC_W·k+ACC_W-1:ACC_W·k]`.
- R8: `out_last` is high only with the final group, whose top lane carries channel 255. `busy` is low in that same cycle.
- R9: Scores are exact signed values in ACC_W = 20 bits, including at input extremes (mask all ones, all LLRs −128 or +127).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offer of a new input vector |
| in_mask | input | 8 | Frozen mask bits, bit j for position j |
| in_llr | input | 64 | Eight signed 8-bit LLRs, LLR j in bits 8j+7:8j |
| busy | output | 1 | High while a scoring pass is under way |
| out_valid | output | 1 | Output group valid |
| out_chan | output | 8·P | Channel index of each lane |
| out_score | output | ACC_W·P | Signed score of each lane |
| out_last | output | 1 | Marks the group that contains channel 255 |

## Verification
The assertions assume that the input vector is sampled only at the acceptance edge. They also assume the block never sees an offer that overlaps a pass in a way that could restart it. The stimulus therefore drives inputs on falling edges, raises `in_valid` for acceptance only once `busy` is low, and during one pass deliberately holds a different vector with `in_valid` high to show it is ignored. The overflow bound in the lanes assumes int8 operands only, and every LLR the bench drives is a byte, including both extremes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int CHANNELS = 256;
  localparam int TERMS    = 8;

  // Generated weight for channel ch, column col (0..15)
  function automatic logic signed [7:0] weight_at(input logic [7:0] ch, input int col);
    logic [15:0] t;
    t = 16'(ch) * 16'd37 + 16'(col) * 16'd101 + 16'(ch ^ 8'(col)) * 16'd13 + 16'd7;
    return t[7:0];
  endfunction

  function automatic logic signed [7:0] bias_at(input logic [7:0] ch);
    logic [15:0] t;
    t = 16'(ch) * 16'd53 + 16'd29;
    return t[7:0];
  endfunction
endpackage

// File: rtl/sbs_mask_pe.sv
module sbs_mask_pe #(
  parameter int ACC_W = 20
) (
  input  logic                    sel,
  input  logic signed [7:0]       weight,
  output logic signed [ACC_W-1:0] term
);
  // single-bit operand: pick the weight or zero instead of multiplying
  assign term = sel ? ACC_W'(weight) : '0;
endmodule

// File: rtl/sbs_llr_pe.sv
module sbs_llr_pe #(
  parameter int ACC_W = 20
) (
  input  logic signed [7:0]       llr,
  input  logic signed [7:0]       weight,
  output logic signed [ACC_W-1:0] term
);
  logic signed [15:0] prod;
  assign prod = llr * weight;
  assign term = ACC_W'(prod);
endmodule

// File: rtl/sbs_lane.sv
module sbs_lane
  import sbs_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic [7:0]              chan,
  input  logic [7:0]              mask,
  input  logic [63:0]             llr,
  output logic signed [ACC_W-1:0] score
);
  localparam int BOUND = TERMS * 128 + TERMS * 128 * 128 + 128;

  logic signed [ACC_W-1:0] mterm [TERMS];
  logic signed [ACC_W-1:0] lterm [TERMS];

  for (genvar j = 0; j < TERMS; j++) begin : g_pe
    sbs_mask_pe #(.ACC_W(ACC_W)) u_mpe (
      .sel(mask[j]), .weight(weight_at(chan, j)), .term(mterm[j]));
    sbs_llr_pe #(.ACC_W(ACC_W)) u_lpe (
      .llr(llr[8*j +: 8]), .weight(weight_at(chan, TERMS + j)), .term(lterm[j]));
  end

  always_comb begin
    score = ACC_W'(bias_at(chan));
    for (int j = 0; j < TERMS; j++) score = score + mterm[j] + lterm[j];
  end

  always_comb begin
    AST_NO_OVERFLOW: assert (score <= ACC_W'(BOUND) && score >= -ACC_W'(BOUND)); // R9
  end
endmodule

// File: rtl/sbs_score_engine.sv
module sbs_score_engine
  import sbs_pkg::*;
#(
  parameter int P     = 4,
  parameter int ACC_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_mask,
  input  logic [63:0]          in_llr,
  output logic                 busy,
  output logic                 out_valid,
  output logic [8*P-1:0]       out_chan,
  output logic [ACC_W*P-1:0]   out_score,
  output logic                 out_last
);
  localparam int NGRP = CHANNELS / P;
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic [GW-1:0]    grp;
  logic [7:0]       mask_q;
  logic [63:0]      llr_q;
  logic [8*P-1:0]   lane_chan;
  logic [ACC_W*P-1:0] lane_score;

  // named events for the assertions
  logic accept_evt, final_grp;
  assign accept_evt = in_valid && !busy;
  assign final_grp  = busy && (grp == GW'(NGRP - 1));

  for (genvar k = 0; k < P; k++) begin : g_lane
    assign lane_chan[8*k +: 8] = 8'(grp * P + k);
    sbs_lane #(.ACC_W(ACC_W)) u_lane (
      .chan (lane_chan[8*k +: 8]),
      .mask (mask_q),
      .llr  (llr_q),
      .score(lane_score[ACC_W*k +: ACC_W]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      grp       <= '0;
      mask_q    <= '0;
      llr_q     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_chan  <= '0;
      out_score <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (accept_evt) begin
        mask_q <= in_mask;
        llr_q  <= in_llr;
        grp    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        out_valid <= 1'b1;
        out_chan  <= lane_chan;
        out_score <= lane_score;
        out_last  <= final_grp;
        if (final_grp) busy <= 1'b0;
        else           grp  <= grp + 1'b1;
      end
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy); // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(llr_q) && $stable(mask_q)); // R3
  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid && out_chan[7:0] == $past(out_chan[7:0]) + 8'(P)); // R7
  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid && !busy && out_chan[8*P-1 -: 8] == 8'hFF); // R8
  AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> busy); // R7
endmodule

// File: tb/sbs_score_engine_tb.sv
module sbs_score_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam int ACC_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_mask = '0;
  logic [63:0] in_llr = '0;
  logic busy, out_valid, out_last;
  logic [8*P-1:0] out_chan;
  logic [ACC_W*P-1:0] out_score;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int qc[$];
  int qs[$];
  string qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbs_score_engine #(.P(P), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask), .in_llr(in_llr),
    .busy(busy), .out_valid(out_valid), .out_chan(out_chan), .out_score(out_score),
    .out_last(out_last));

  function automatic int sx8(int v);
    v = v & 255;
    return (v >= 128) ? v - 256 : v;
  endfunction

  // R6 rule restated
  function automatic int wref(int c, int k);
    return sx8(37*c + 101*k + 13*(c ^ k) + 7);
  endfunction

  function automatic int ref_score(int c, logic [7:0] m, logic [63:0] l);
    int acc = sx8(53*c + 29);
    for (int j = 0; j < 8; j++) begin
      if (m[j]) acc += wref(c, j);
      acc += wref(c, 8 + j) * sx8(int'(l[8*j +: 8]));
    end
    return acc;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vector(logic [7:0] m, logic [63:0] l, string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1; in_mask = m; in_llr = l;
    for (int c = 0; c < 256; c++) begin
      qc.push_back(c); qs.push_back(ref_score(c, m, l)); qt.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_drain();
    while (qc.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        for (int k = 0; k < P; k++) begin
          if (qc.size() == 0) begin
            check(0, "R3 unexpected output", int'(out_chan[8*k +: 8]), -1);
          end else begin
            int ec, es; string et;
            ec = qc.pop_front(); es = qs.pop_front(); et = qt.pop_front();
            check(int'(out_chan[8*k +: 8]) == ec, "R7 channel index", int'(out_chan[8*k +: 8]), ec);
            check(int'($signed(out_score[ACC_W*k +: ACC_W])) == es, et,
                  int'($signed(out_score[ACC_W*k +: ACC_W])), es);
            if (k == P - 1) begin
              check(out_last == (ec == 255), "R8 last flag", int'(out_last), int'(ec == 255));
              if (ec == 255) check(busy == 1'b0, "R8 busy low with last", int'(busy), 0);
            end
          end
        end
      end else if (qc.size() > 0 && qc.size() < 256) begin
        check(0, "R7 gap in stream", 0, 1);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && out_valid == 0 && out_last == 0, "R1 reset state",
          int'({busy, out_valid, out_last}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && out_valid == 0, "R1 idle after reset", int'({busy, out_valid}), 0);

    run_vector(8'h00, 64'h0, "R6 bias only");
    wait_drain();
    run_vector(8'hFF, 64'h0, "R4 mask all ones");
    wait_drain();
    run_vector(8'hA5, 64'h0, "R4 mask pattern");
    wait_drain();
    run_vector(8'h3C, 64'h80_7F_01_FF_40_C0_10_F3, "R5 mixed LLR");
    wait_drain();
    run_vector(8'hFF, {8{8'h80}}, "R9 extreme negative");
    wait_drain();
    run_vector(8'hFF, {8{8'h7F}}, "R9 extreme positive");
    // R3: offer another vector while busy
    @(negedge clk);
    in_valid = 1'b1; in_mask = 8'h0F; in_llr = {8{8'h11}};
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    wait_drain();
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 0 && busy == 0, "R3 no extra pass", int'({out_valid, busy}), 0);
    end
    run_vector(8'h81, 64'hF0_E1_D2_C3_B4_A5_96_87, "R5 second LLR pattern");
    wait_drain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule